// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one data word per handshake into an asynchronous serial frame on a single output line. The frame shape is chosen at run time by a set of mode inputs. They select how many data bits are sent, whether a parity bit follows them and which parity sense it uses, one or two stop bits, whether the data goes out low bit first or high bit first, and whether the line uses true or inverted levels.

The mode inputs are captured on the cycle a word is accepted, and they stay fixed for that whole frame. Bit timing comes from an external one-cycle enable pulse at sixteen times the bit rate. Every frame element is held on the line for sixteen of these pulses. A frame holds a start bit, the data field, an optional parity bit and one or two stop bits, so it lasts 7 to 12 bit times. The busy flag covers the frame from acceptance until the end of its final stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, with true levels selected, the line is high, busy is low and ready is high.
- R2: len_sel selects the data field length: code 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Input word bits above the selected length have no effect on the line.
- R3: With par_en high, a parity bit follows the data field. Parity is taken over the selected data bits only. par_odd low gives even parity (the count of ones in data plus parity is even), and par_odd high gives odd parity. With par_en low, no parity bit is sent.
- R4: stop_two low sends one stop bit and stop_two high sends two. With true levels, a stop bit is high.
- R5: msb_first low sends data bit 0 first. msb_first high sends the top selected bit (bit length-1) first.
- R6: With line_inv high, every level on the line is inverted: the idle level, the start bit, the data, parity and stop bits. With true levels, the start bit is low.
- R7: Each frame element lasts exactly 16 baud_tick pulses, and the line does not advance without them. Busy stays high until the 16th pulse of the last stop bit, then clears, so a frame lasts 1 + length + parity + stops bit times (7 to 12).
- R8: ready is high exactly when the block is idle. A word is accepted on a clock where in_valid and ready are both high. A valid presented while busy is dropped and never sent.
- R9: The mode inputs are sampled when a word is accepted. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| in_data | input | 8 | Word to send |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block is idle and can take a word |
| len_sel | input | 2 | Data length code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_two | input | 1 | 1 = two stop bits, 0 = one |
| msb_first | input | 1 | 1 = high bit first, 0 = low bit first |
| line_inv | input | 1 | 1 = inverted line levels |
| tx_line | output | 1 | Serial output |
| tx_busy | output | 1 | Frame in progress |

## Verification
A wrong frame image shows up in the middle sample of the first bit slot that differs, so the fault appears within one bit time of its position in the frame. A wrong length count or a bad bit timer shows up as busy clearing one bit time early or late, or as line edges that fall between ticks. A bad capture of the polarity latch shows up at once as a wrong idle or start level. A handshake fault, such as taking a word while busy, shows up as an extra frame after the expected one, or as a corrupted frame.

// File: rtl/uft_pkg.sv
package uft_pkg;
   // Run-time frame format, captured on the accept cycle
   typedef struct packed {
      logic [1:0] len_code;
      logic       par_en;
      logic       par_odd;
      logic       stop_two;
      logic       msb_first;
      logic       line_inv;
   } uft_mode_t;
endpackage

// File: rtl/uft_frame_build.sv
module uft_frame_build #(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   parameter int FRAME_W = DATA_W + 4,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  word,
   input  uft_pkg::uft_mode_t mode,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   frame_len
);
   // Positive-logic image of the frame, element 0 goes out first
   logic [DATA_W-1:0] field;
   logic              par_bit;
   int                nbits;
   int                pos;

   always_comb begin
      nbits   = MIN_LEN + int'(mode.len_code);
      field   = '0;
      par_bit = mode.par_odd;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < nbits) begin
            field[i] = mode.msb_first ? word[nbits-1-i] : word[i];
            par_bit  = par_bit ^ word[i];
         end
      end
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < nbits) frame[1+i] = field[i];
      end
      pos = 1 + nbits;
      if (mode.par_en) begin
         frame[pos] = par_bit;
         pos        = pos + 1;
      end
      pos       = pos + (mode.stop_two ? 2 : 1);
      frame_len = CNT_W'(pos);
   end
endmodule

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
   parameter int TICKS = 16,
   parameter int TW    = (TICKS > 1) ? $clog2(TICKS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick,
   output logic bit_end
);
   logic [TW-1:0] cnt;
   logic          at_last;

   assign at_last = (cnt == TW'(TICKS - 1));
   assign bit_end = tick & at_last & ~restart;

   generate
      if ((1 << TW) == TICKS) begin : g_wrap
         // power-of-two span: natural wrap, no compare in the next-state path
         always_ff @(posedge clk) begin
            if (!rst_n || restart) cnt <= '0;
            else if (tick)         cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || restart) cnt <= '0;
            else if (tick)         cnt <= at_last ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/uft_frame_shift.sv
module uft_frame_shift #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   frame_len,
   input  logic               bit_end,
   output logic               busy,
   output logic               cur_bit
);
   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sh   <= frame;
         left <= frame_len;
         busy <= 1'b1;
      end else if (busy && bit_end) begin
         sh   <= {1'b1, sh[FRAME_W-1:1]};
         left <= left - 1'b1;
         if (left == CNT_W'(1)) busy <= 1'b0;
      end
   end

   assign cur_bit = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int DATA_W        = 8,
   parameter int MIN_LEN       = 5,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        len_sel,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop_two,
   input  logic              msb_first,
   input  logic              line_inv,
   output logic              tx_line,
   output logic              tx_busy
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (MIN_LEN + 3 > DATA_W || MIN_LEN < 1) begin : g_bad_len
         $error("uart_frame_tx: length codes exceed DATA_W");
      end
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("uart_frame_tx: TICKS_PER_BIT must be at least 2");
      end
   endgenerate

   uft_pkg::uft_mode_t mode_in;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   frame_len;
   logic               accept;
   logic               bit_end;
   logic               busy;
   logic               cur_bit;
   logic               inv_q;

   assign mode_in  = '{len_code: len_sel, par_en: par_en, par_odd: par_odd,
                       stop_two: stop_two, msb_first: msb_first, line_inv: line_inv};
   assign accept   = in_valid & ~busy;
   assign in_ready = ~busy;
   assign tx_busy  = busy;

   uft_frame_build #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
      .word(in_data), .mode(mode_in), .frame(frame), .frame_len(frame_len));

   uft_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(accept), .tick(baud_tick), .bit_end(bit_end));

   uft_frame_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .frame(frame), .frame_len(frame_len),
      .bit_end(bit_end), .busy(busy), .cur_bit(cur_bit));

   // polarity follows the input while idle, frozen while a frame runs
   always_ff @(posedge clk) begin
      if (!rst_n)    inv_q <= 1'b0;
      else if (!busy) inv_q <= line_inv;
   end

   assign tx_line = inv_q ^ cur_bit;
endmodule

// File: rtl/uft_tx_checker.sv
module uft_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic in_valid,
   input logic in_ready,
   input logic tx_line,
   input logic tx_busy,
   input logic inv_q
);
   assert_accept_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> tx_busy);
   assert_busy_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(in_valid));
   assert_start_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> tx_line == inv_q);
   assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> tx_line == !inv_q);
   assert_line_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy && $past(tx_busy) && !$stable(tx_line) |-> $past(baud_tick));
   assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> $past(baud_tick));
   assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy && $past(tx_busy) |-> $stable(inv_q));
endmodule

bind uart_frame_tx uft_tx_checker u_chk (
   .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
   .in_ready(in_ready), .tx_line(tx_line), .tx_busy(tx_busy), .inv_q(inv_q));

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [1:0] len_sel = 2'd3;
   logic       par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0, msb_first = 1'b0, line_inv = 1'b0;
   logic       tx_line, tx_busy;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   uart_frame_tx u_uart_frame_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .len_sel(len_sel), .par_en(par_en),
      .par_odd(par_odd), .stop_two(stop_two), .msb_first(msb_first), .line_inv(line_inv),
      .tx_line(tx_line), .tx_busy(tx_busy));

   // vector: {data[7:0], len[1:0], par_en, par_odd, stop_two, msb_first, inv}
   localparam int NV = 8;
   localparam logic [14:0] VEC [NV] = '{
      {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'hFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'hE0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h5B, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
      {8'h96, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      {8'h01, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int frame_bits(input logic [6:0] m);
      return 1 + 5 + int'(m[6:5]) + int'(m[4]) + (m[2] ? 2 : 1);
   endfunction

   function automatic logic [11:0] frame_levels(input logic [7:0] d, input logic [6:0] m);
      logic [11:0] f = '1;
      int          n = 5 + int'(m[6:5]);
      int          k = 1;
      logic        p = m[3];
      f[0] = 1'b0;
      for (int i = 0; i < n; i++) begin
         f[k] = m[1] ? d[n-1-i] : d[i];
         p    = p ^ f[k];
         k++;
      end
      if (m[4]) f[k] = p;
      if (m[0]) f = ~f;
      return f;
   endfunction

   task automatic set_mode(input logic [6:0] m);
      {len_sel, par_en, par_odd, stop_two, msb_first, line_inv} = m;
   endtask

   task automatic pulse_tick();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
   endtask

   task automatic run_frame(input logic [7:0] d, input logic [6:0] m, input bit disturb);
      int          n    = frame_bits(m);
      logic [11:0] mask = 12'((13'd1 << n) - 1);
      logic [11:0] e    = frame_levels(d, m) & mask;
      logic [11:0] got  = '0;
      @(negedge clk);
      in_data = d; set_mode(m); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(tx_busy && !in_ready, "R8", "busy after accept", {tx_busy, in_ready}, 2'b10);
      if (disturb) begin
         // new word and new format while busy: both must be ignored (R8, R9)
         in_data = ~d; set_mode(~m); in_valid = 1'b1;
         @(negedge clk) in_valid = 1'b0;
      end
      for (int b = 0; b < n; b++) begin
         for (int t = 1; t <= 16; t++) begin
            pulse_tick();
            if (t == 8) got[b] = tx_line;
            if (b == n - 1 && t == 15)
               chk(tx_busy, "R7", "busy through last stop", tx_busy, 1);
         end
      end
      chk(got == e, "R2/R3/R4/R5/R6/R9", "frame levels", got, e);
      chk(!tx_busy && in_ready, "R7", "busy clears after frame", {tx_busy, in_ready}, 2'b01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(tx_line && !tx_busy && in_ready, "R1", "reset state",
          {tx_line, tx_busy, in_ready}, 3'b101);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(tx_line && in_ready, "R1", "idle after reset", {tx_line, in_ready}, 2'b11);

      for (int v = 0; v < NV; v++)
         run_frame(VEC[v][14:7], VEC[v][6:0], 1'b0);

      // mode and word changes mid-frame are ignored
      run_frame(8'hC3, 7'b11_1_0_0_0_0, 1'b1);
      for (int t = 0; t < 40; t++) pulse_tick();
      chk(!tx_busy, "R8", "word offered while busy not sent", tx_busy, 0);
      chk(tx_line == 1'b0, "R6", "inverted idle level", tx_line, 0);
      set_mode(7'b11_0_0_0_0_0);
      @(negedge clk); @(negedge clk);
      chk(tx_line == 1'b1, "R6", "true idle level", tx_line, 1);

      // no ticks: the start bit holds
      @(negedge clk) begin in_data = 8'h55; in_valid = 1'b1; end
      @(negedge clk) in_valid = 1'b0;
      repeat (100) @(negedge clk);
      chk(tx_busy && tx_line == 1'b0, "R7", "start held without ticks",
          {tx_busy, tx_line}, 2'b10);
      for (int t = 0; t < 16 * 10; t++) pulse_tick();
      chk(!tx_busy, "R7", "8N1 frame done after 10 bit times", tx_busy, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule